// File: doc/BRIEF.md
# Wake-up clock request sequencer

This block brings a wireless chip from reset to an active state. It runs from a 32.768 kHz sleep clock. It waits for the internal power-on reset to release. After a fixed delay it shows a readiness signature that the host polls. The host then sets a wake bit. In response the block raises a reference-clock request and counts a programmable number of sleep-clock ticks so that the clock has time to settle.

When the count ends, the PLL configuration register opens to the host. The block then waits for the PLL to report lock. On lock it raises a chip-active interrupt, which stays high until the host clears it. Clearing the wake bit at any point after the request drops the request and returns the block to its ready state.

A simple register port stands in for the host transport. A write takes effect at the next clock edge. A read returns the value for the current address combinationally.

Top module: `wkup_refclk_seq`

## Requirements
- R1: After reset the clock request and the interrupt are low and `pll_word` is 0. The status register (0x08) reads 0, and the settle register (0x04) reads 255.
- R2: In the reset state the block waits for `por_done`. From the clock edge that samples `por_done` high, 16 more edges pass and the block is then ready. Address 0x14 reads 32'hA5C3_0F1E in the ready state and every state after it, and reads 0 before that.
- R3: Writing 1 to bit 0 of the control register (0x00) while the block is ready moves it to the settle-wait state. `refclk_req` goes high at the edge after the write and stays high through the wait, configuration and active states.
- R4: The settle register (bits [7:0] at 0x04) sets how many cycles the settle-wait state lasts. A value of 0 acts as 1, and the default of 255 gives 255 cycles.
- R5: The PLL register (0x0C) opens only in the configuration and active states. At any other time, writes to it are ignored and reads of it return 0. The value of the register drives `pll_word`.
- R6: In the configuration state, `pll_locked` moves the block to the active state and sets `chip_irq`. Lock that arrives earlier sets nothing until the settle wait has ended.
- R7: `chip_irq` stays high until a write to the status register with bit 0 set clears it. A write with bit 0 clear leaves it high.
- R8: Clearing the wake bit in the settle-wait, configuration or active state returns the block to ready at the next edge, and `refclk_req` drops.
- R9: The status register (0x08) has these fields: bit 0 is the interrupt flag, bit 1 is high while the PLL register is open, and bits [6:4] hold the state code. The codes are reset=0, POR delay=1, ready=2, settle wait=3, configuration=4 and active=5. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sleep clock |
| rst_n | input | 1 | Synchronous active-low external reset |
| por_done | input | 1 | Internal power-on reset released |
| pll_locked | input | 1 | PLL lock indication |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| refclk_req | output | 1 | Reference-clock request |
| chip_irq | output | 1 | Chip-active interrupt |
| pll_word | output | 32 | Current PLL configuration value |

## Verification
The bench measures how long the settle wait lasts at the extreme settings of 0, 3 and 255. A design that loaded the count off by one, or that treated 0 as 256, would give the wrong length. It writes the PLL register during the wait and also holds the lock input high before the wait ends. A design that opened the register too early would change `pll_word`, and one that armed the interrupt too early would raise it before configuration. It also clears the wake bit in the middle of a wait, and it clears the interrupt with a write whose bit 0 is zero. These catch a request that stays high after wake is cleared and an interrupt that clears on any status write.

// File: rtl/wks_pkg.sv
// Shared types and register addresses for the wake-up clock request sequencer.
// Assumes byte addressing with 32-bit registers.
package wks_pkg;
    typedef enum logic [2:0] {
        ST_RESET  = 3'd0,
        ST_POR    = 3'd1,
        ST_READY  = 3'd2,
        ST_WAIT   = 3'd3,
        ST_CFG    = 3'd4,
        ST_ACTIVE = 3'd5
    } wks_state_e;

    localparam logic [7:0] A_CTRL   = 8'h00;
    localparam logic [7:0] A_SETTLE = 8'h04;
    localparam logic [7:0] A_STAT   = 8'h08;
    localparam logic [7:0] A_PLL    = 8'h0C;
    localparam logic [7:0] A_SIG    = 8'h14;
endpackage

// File: rtl/wks_tick_cnt.sv
// Down-counter of sleep-clock ticks, shared by the POR delay and the settle wait.
// Assumes load takes priority over decrement; the count stops at zero.
module wks_tick_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         last
);
    // Load a new window, or count one tick of the current window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // The final tick of a window.
    assign last = (cnt == W'(1));
endmodule

// File: rtl/wks_fsm.sv
// Sequencing state machine: reset, POR delay, ready, settle wait, PLL configuration, active.
// Assumes the wake bit is level-held by the register block and the counter is external.
module wks_fsm
    import wks_pkg::*;
#(
    parameter int POR_CYCLES = 16,
    parameter int SETTLE_W   = 8,
    parameter int CNT_W      = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                por_done,
    input  logic                wake,
    input  logic [SETTLE_W-1:0] settle,
    input  logic                pll_locked,
    input  logic [CNT_W-1:0]    cnt,
    input  logic                cnt_last,
    output wks_state_e          state,
    output logic                cnt_load,
    output logic [CNT_W-1:0]    cnt_val,
    output logic                cnt_dec,
    output logic                lock_evt
);
    wks_state_e          state_nx;
    logic [SETTLE_W-1:0] settle_eff;

    // A settle value of zero is treated as one tick.
    assign settle_eff = (settle == '0) ? SETTLE_W'(1) : settle;

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RESET:  if (por_done) state_nx = ST_POR;
            ST_POR:    if (cnt_last) state_nx = ST_READY;
            ST_READY:  if (wake) state_nx = ST_WAIT;
            ST_WAIT:   if (!wake) state_nx = ST_READY;
                       else if (cnt_last) state_nx = ST_CFG;
            ST_CFG:    if (!wake) state_nx = ST_READY;
                       else if (pll_locked) state_nx = ST_ACTIVE;
            ST_ACTIVE: if (!wake) state_nx = ST_READY;
            default:   state_nx = ST_RESET;
        endcase
    end

    // Counter control: load a window on entry to a timed state, count down inside it.
    always_comb begin
        cnt_load = 1'b0;
        cnt_val  = '0;
        if (state == ST_RESET && por_done) begin
            cnt_load = 1'b1;
            cnt_val  = CNT_W'(POR_CYCLES);
        end else if (state == ST_READY && wake) begin
            cnt_load = 1'b1;
            cnt_val  = CNT_W'(settle_eff);
        end
        cnt_dec = (state == ST_POR) || (state == ST_WAIT);
    end

    // Lock is only taken while configuring with wake still set.
    assign lock_evt = (state == ST_CFG) && wake && pll_locked;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_RESET;
        else
            state <= state_nx;
    end

    // The settle window never runs with an empty count.
    p_cnt_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> (cnt != '0));

    // Configuration is entered only from the settle wait.
    p_cfg_from_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CFG && $past(state) != ST_CFG) |-> ($past(state) == ST_WAIT));

    // Leaving the POR delay for ready only at the final tick.
    p_por_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY && $past(state) == ST_POR) |-> $past(cnt_last));

    // Active is entered only on a lock seen while configuring.
    p_active_on_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && $past(state) != ST_ACTIVE) |-> ($past(state) == ST_CFG && $past(pll_locked)));
endmodule

// File: rtl/wks_regs.sv
// Host register file: wake control, settle count, status with write-one-to-clear flag,
// gated PLL word and the ready signature. Assumes writes land on the next edge.
module wks_regs
    import wks_pkg::*;
#(
    parameter int          SETTLE_W   = 8,
    parameter int          DEF_SETTLE = 255,
    parameter logic [31:0] READY_SIG  = 32'hA5C3_0F1E
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wen,
    input  logic [7:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    input  wks_state_e          state,
    input  logic                lock_evt,
    output logic                wake,
    output logic [SETTLE_W-1:0] settle,
    output logic                irq,
    output logic [31:0]         pll_word,
    output logic                pll_open,
    output logic [31:0]         bus_rdata
);
    logic sig_vis;
    logic wr_ctrl, wr_settle, wr_stat, wr_pll;

    assign pll_open  = (state == ST_CFG) || (state == ST_ACTIVE);
    assign sig_vis   = (state != ST_RESET) && (state != ST_POR);
    assign wr_ctrl   = bus_wen && (bus_addr == A_CTRL);
    assign wr_settle = bus_wen && (bus_addr == A_SETTLE);
    assign wr_stat   = bus_wen && (bus_addr == A_STAT);
    assign wr_pll    = bus_wen && (bus_addr == A_PLL);

    // Wake bit from the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wake <= 1'b0;
        else if (wr_ctrl)
            wake <= bus_wdata[0];
    end

    // Settle count register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            settle <= SETTLE_W'(DEF_SETTLE);
        else if (wr_settle)
            settle <= bus_wdata[SETTLE_W-1:0];
    end

    // PLL word, writable only once the reference clock is settled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pll_word <= '0;
        else if (wr_pll && pll_open)
            pll_word <= bus_wdata;
    end

    // Interrupt flag: set on lock, cleared by writing one; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (lock_evt)
            irq <= 1'b1;
        else if (wr_stat && bus_wdata[0])
            irq <= 1'b0;
    end

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL:   bus_rdata = {31'b0, wake};
            A_SETTLE: bus_rdata = 32'(settle);
            A_STAT:   bus_rdata = {25'b0, state, 2'b0, pll_open, irq};
            A_PLL:    bus_rdata = pll_open ? pll_word : 32'h0;
            A_SIG:    bus_rdata = sig_vis ? READY_SIG : 32'h0;
            default:  bus_rdata = '0;
        endcase
    end

    // Closed PLL register ignores writes.
    p_pll_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == A_PLL && !pll_open) |=> $stable(pll_word));

    // Interrupt held until a one is written to the flag.
    p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(wr_stat && bus_wdata[0])) |=> irq);

    // Interrupt rises only on a lock event from the sequencer.
    p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(lock_evt));

    // Signature hidden until the POR delay has passed.
    p_sig_hidden_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_SIG && (state == ST_RESET || state == ST_POR)) |-> (bus_rdata == 32'h0));
endmodule

// File: rtl/wkup_refclk_seq.sv
// Top of the wake-up clock request sequencer. Connects the state machine, the tick
// counter and the register file. Assumes a single sleep-clock domain.
module wkup_refclk_seq
    import wks_pkg::*;
#(
    parameter int          POR_CYCLES = 16,
    parameter int          SETTLE_W   = 8,
    parameter int          DEF_SETTLE = 255,
    parameter logic [31:0] READY_SIG  = 32'hA5C3_0F1E
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        por_done,
    input  logic        pll_locked,
    input  logic        bus_wen,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        refclk_req,
    output logic        chip_irq,
    output logic [31:0] pll_word
);
    localparam int POR_W = $clog2(POR_CYCLES + 1);
    localparam int CNT_W = (POR_W > SETTLE_W) ? POR_W : SETTLE_W;

    wks_state_e          state;
    logic                wake, lock_evt, pll_open;
    logic [SETTLE_W-1:0] settle;
    logic                cnt_load, cnt_dec, cnt_last;
    logic [CNT_W-1:0]    cnt_val, cnt;

    wks_tick_cnt #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
        .dec(cnt_dec), .cnt(cnt), .last(cnt_last)
    );

    wks_fsm #(.POR_CYCLES(POR_CYCLES), .SETTLE_W(SETTLE_W), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .por_done(por_done), .wake(wake), .settle(settle),
        .pll_locked(pll_locked), .cnt(cnt), .cnt_last(cnt_last), .state(state),
        .cnt_load(cnt_load), .cnt_val(cnt_val), .cnt_dec(cnt_dec), .lock_evt(lock_evt)
    );

    wks_regs #(.SETTLE_W(SETTLE_W), .DEF_SETTLE(DEF_SETTLE), .READY_SIG(READY_SIG)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .state(state), .lock_evt(lock_evt), .wake(wake),
        .settle(settle), .irq(chip_irq), .pll_word(pll_word), .pll_open(pll_open),
        .bus_rdata(bus_rdata)
    );

    // The request is held from the settle wait onwards.
    assign refclk_req = (state == ST_WAIT) || (state == ST_CFG) || (state == ST_ACTIVE);

    // A cleared wake bit withdraws the request by the next edge.
    p_req_follows_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wake |=> !refclk_req);

    // The PLL register is never open without the clock request.
    p_open_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pll_open |-> refclk_req);
endmodule

// File: tb/wkup_refclk_seq_test.sv
`timescale 1ns/100ps
module wkup_refclk_seq_test;
    localparam logic [31:0] SIG = 32'hA5C3_0F1E;

    logic        clk = 1'b0;
    logic        rst_n, por_done, pll_locked, bus_wen;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata, pll_word;
    logic        refclk_req, chip_irq;

    int nchk = 0, nfail = 0, cyc = 0;
    bit model_ok = 1'b0;

    // Behavioural reference model state.
    int          m_st, m_cnt, m_settle;
    bit          m_wake, m_irq;
    logic [31:0] m_pll;

    always #2 clk = ~clk;

    wkup_refclk_seq uut (
        .clk(clk), .rst_n(rst_n), .por_done(por_done), .pll_locked(pll_locked),
        .bus_wen(bus_wen), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .refclk_req(refclk_req), .chip_irq(chip_irq),
        .pll_word(pll_word)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    function automatic bit m_open();
        return (m_st == 4) || (m_st == 5);
    endfunction

    function automatic logic [31:0] m_rd(logic [7:0] a);
        case (a)
            8'h00: return {31'b0, m_wake};
            8'h04: return 32'(m_settle);
            8'h08: return (32'(m_st) << 4) | (32'(m_open()) << 1) | 32'(m_irq);
            8'h0C: return m_open() ? m_pll : 32'h0;
            8'h14: return (m_st >= 2) ? SIG : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    // Reference model: advance one sleep-clock cycle from the current inputs.
    always @(posedge clk) begin
        int  ns, nc;
        bit  nw, ni;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_settle = 255; m_wake = 0; m_irq = 0; m_pll = 0;
            model_ok = 1'b1;
        end else begin
            ns = m_st; nc = m_cnt; nw = m_wake; ni = m_irq;
            case (m_st)
                0: if (por_done) begin ns = 1; nc = 16; end
                1: if (m_cnt == 1) ns = 2; else nc = m_cnt - 1;
                2: if (m_wake) begin ns = 3; nc = (m_settle == 0) ? 1 : m_settle; end
                3: if (!m_wake) ns = 2; else if (m_cnt == 1) ns = 4; else nc = m_cnt - 1;
                4: if (!m_wake) ns = 2; else if (pll_locked) ns = 5;
                5: if (!m_wake) ns = 2;
                default: ns = 0;
            endcase
            if (m_st == 3 && !m_wake) nc = (m_cnt > 0) ? m_cnt - 1 : 0;
            if (bus_wen && bus_addr == 8'h08 && bus_wdata[0]) ni = 0;
            if (m_st == 4 && m_wake && pll_locked) ni = 1;
            if (bus_wen && bus_addr == 8'h00) nw = bus_wdata[0];
            if (bus_wen && bus_addr == 8'h04) m_settle = int'(bus_wdata[7:0]);
            if (bus_wen && bus_addr == 8'h0C && m_open()) m_pll = bus_wdata;
            m_st = ns; m_cnt = nc; m_wake = nw; m_irq = ni;
        end
    end

    // Compare every cycle away from the active edge.
    always @(negedge clk) begin
        if (model_ok && rst_n) begin
            chk("R3 refclk_req", 32'(refclk_req), 32'(m_st >= 3));
            chk("R6 chip_irq", 32'(chip_irq), 32'(m_irq));
            chk("R5 pll_word", pll_word, m_pll);
            chk("R9 bus_rdata", bus_rdata, m_rd(bus_addr));
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            nfail++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_up();
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #0.5;
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wen = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.3;
        d = bus_rdata;
    endtask

    // Count cycles spent in the settle wait after a wake write.
    task automatic measure_wait(output int n);
        logic [31:0] s;
        n = 0;
        for (int i = 0; i < 400; i++) begin
            tick();
            rd(8'h08, s);
            if (s[6:4] == 3'd3) n++;
            else if (n > 0) break;
        end
    endtask

    initial begin
        logic [31:0] v;
        int n;
        rst_n = 0; por_done = 0; pll_locked = 0; bus_wen = 0; bus_addr = 0; bus_wdata = 0;
        tick(4);
        rst_n = 1;
        rd(8'h08, v); chk("R1 status after reset", v, 32'h0);
        rd(8'h04, v); chk("R1 settle default", v, 32'd255);
        chk("R1 refclk_req", 32'(refclk_req), 0);
        chk("R1 chip_irq", 32'(chip_irq), 0);
        chk("R1 pll_word", pll_word, 0);
        tick(3);
        rd(8'h14, v); chk("R2 signature hidden without POR", v, 32'h0);
        wr(8'h0C, 32'hDEAD_BEEF);
        chk("R5 early PLL write ignored", pll_word, 32'h0);

        por_done = 1;
        tick(16);
        rd(8'h14, v); chk("R2 signature hidden at 16 edges", v, 32'h0);
        tick();
        rd(8'h14, v); chk("R2 signature visible at 17 edges", v, SIG);
        rd(8'h08, v); chk("R9 ready state code", 32'(v[6:4]), 2);

        wr(8'h04, 32'd3);
        wr(8'h00, 32'd1);
        measure_wait(n);
        chk("R4 wait length settle=3", 32'(n), 3);
        chk("R3 request high in config", 32'(refclk_req), 1);
        rd(8'h08, v); chk("R9 open bit in config", 32'(v[1]), 1);
        wr(8'h0C, 32'h1234_5678);
        chk("R5 PLL write when open", pll_word, 32'h1234_5678);
        rd(8'h0C, v); chk("R5 PLL readback", v, 32'h1234_5678);
        tick(5);
        chk("R6 no irq before lock", 32'(chip_irq), 0);
        pll_locked = 1;
        tick();
        chk("R6 irq on lock", 32'(chip_irq), 1);
        pll_locked = 0;
        tick(3);
        chk("R7 irq held", 32'(chip_irq), 1);
        wr(8'h08, 32'h0);
        chk("R7 zero write keeps irq", 32'(chip_irq), 1);
        wr(8'h08, 32'h1);
        chk("R7 irq cleared", 32'(chip_irq), 0);
        rd(8'h08, v); chk("R9 active state code", 32'(v[6:4]), 5);
        wr(8'h00, 32'd0);
        tick();
        chk("R8 request dropped", 32'(refclk_req), 0);
        rd(8'h08, v); chk("R8 back to ready", 32'(v[6:4]), 2);

        // Zero settle acts as one; lock held early.
        wr(8'h04, 32'd0);
        pll_locked = 1;
        wr(8'h00, 32'd1);
        measure_wait(n);
        chk("R4 wait length settle=0", 32'(n), 1);
        chk("R6 early lock gives no irq before config", 32'(chip_irq), 0);
        tick();
        chk("R6 irq after config with held lock", 32'(chip_irq), 1);
        wr(8'h08, 32'h1);

        // Writes during the settle wait, then wake cleared mid-wait.
        wr(8'h00, 32'd0);
        tick();
        pll_locked = 0;
        wr(8'h04, 32'd20);
        wr(8'h00, 32'd1);
        tick(3);
        wr(8'h0C, 32'h0000_CAFE);
        chk("R5 write during wait ignored", pll_word, 32'h1234_5678);
        rd(8'h0C, v); chk("R5 read during wait is zero", v, 32'h0);
        chk("R3 request during wait", 32'(refclk_req), 1);
        wr(8'h00, 32'd0);
        tick();
        chk("R8 request dropped mid-wait", 32'(refclk_req), 0);
        rd(8'h12, v); chk("R9 unmapped read", v, 32'h0);

        // Default settle after a fresh reset.
        rst_n = 0;
        tick(3);
        rst_n = 1;
        rd(8'h04, v); chk("R1 settle default after reset", v, 32'd255);
        tick(18);
        wr(8'h00, 32'd1);
        measure_wait(n);
        chk("R4 wait length default", 32'(n), 255);
        tick(2);
        finish_up();
    end
endmodule